// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation miss by reading page-table descriptors from memory. When a walk is requested it latches the virtual address and the table base register. It reads one first-level descriptor and, if that descriptor points to a second-level table, reads one second-level descriptor as well. It then decodes the result into a fill record for the translation cache, or reports a fault.

The fill record holds the masked virtual address, the masked physical address, the permission bits, the domain and the mapping kind. Descriptors arrive over a minimal memory port: a single-cycle request carries the word address, and the reply comes back with a valid strobe after any number of cycles.

The walk ends with a one-cycle completion strobe that carries a fault code. The block also keeps the domain of the most recent access, which the permission logic uses when it reports a fault.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low and `last_domain` is 0.
- R2: The cycle after a walk is accepted, `mem_req` pulses for exactly one cycle. The first-level address is ((`tbl_base` AND 0xFFFFC000) OR (`walk_va` >> 18)) with bits [1:0] cleared.
- R3: A first-level descriptor with bits [1:0] equal to 0 or 3 ends the walk with fault code 1 (section fault). No second read is made, and `last_domain` is left unchanged.
- R4: A first-level descriptor with bits [1:0] = 2 is a section. The fill has map code 3, va = `walk_va` AND 0xFFF00000, pa = descriptor AND 0xFFF00000, perm = descriptor AND 0x00000C0C, and domain = descriptor bits [8:5].
- R5: A first-level descriptor with bits [1:0] = 1 causes one further read. Its address is ((descriptor AND 0xFFFFFC00) OR ((`walk_va` AND 0x000FF000) >> 10)) with bits [1:0] cleared.
- R6: A second-level descriptor with bits [1:0] equal to 0 or 3 ends the walk with fault code 2 (page fault). `last_domain` becomes first-level descriptor bits [8:5].
- R7: A second-level descriptor with bits [1:0] = 1 is a large page. The fill has map code 2 and masks 0xFFFF0000 on both va and pa (pa taken from the second-level descriptor). Perm = second-level descriptor AND 0x00000FFC, and domain = first-level descriptor bits [8:5].
- R8: A second-level descriptor with bits [1:0] = 2 is a small page. The fill has map code 1 and mask 0xFFFFF000, with perm and domain formed as in R7.
- R9: `done` is high for exactly one cycle per walk. `fault` is valid with it, coded 0 none, 1 section, 2 page, and `busy` falls the cycle after.
- R10: A successful walk sets `last_domain` to the domain of the fill.
- R11: A `walk_req` seen while `busy` is high is dropped. It causes no memory read and no extra `done`.
- R12: The walker waits any number of cycles for `mem_valid` after each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_req | input | 1 | Start a walk (taken only when idle) |
| walk_va | input | 32 | Virtual address that missed |
| tbl_base | input | 32 | Translation table base register |
| busy | output | 1 | Walk in progress, including the done cycle |
| mem_req | output | 1 | One-cycle descriptor read request |
| mem_addr | output | 32 | Word address of the descriptor read |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | Walk complete, one cycle |
| fault | output | 2 | 0 none, 1 section fault, 2 page fault |
| fill_va | output | 32 | Masked virtual address of the fill |
| fill_pa | output | 32 | Masked physical address of the fill |
| fill_perm | output | 32 | Permission bits of the fill |
| fill_domain | output | 4 | Domain of the fill |
| fill_map | output | 2 | Map code: 1 small page, 2 large page, 3 section |
| last_domain | output | 4 | Domain of the last access |

## Verification
A wrong state or a wrong latched descriptor shows first as a bad or missing read on the memory port. That read is either at the wrong address or is an extra second-level read after a section or a faulting first level, so the scoreboard flags it at the request itself, one cycle after acceptance or after the first reply. A wrong decode shows at the completion strobe, in the fault code, the fill fields or `last_domain`, and the same done cycle also reveals when a section fault has overwritten the stored domain. A walker stuck out of idle shows as a missing `done` or a `busy` that stays high after it.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int WORD_W = 32;
    localparam int DOM_W  = 4;
    localparam int DOM_LSB = 5;
    localparam int L1_SHIFT = 18;
    localparam int L2_SHIFT = 10;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [DOM_W-1:0]  dom_t;

    localparam word_t L1_BASE_MASK   = 32'hFFFF_C000;
    localparam word_t L2_BASE_MASK   = 32'hFFFF_FC00;
    localparam word_t L2_INDEX_MASK  = 32'h000F_F000;
    localparam word_t SEC_PERM_MASK  = 32'h0000_0C0C;
    localparam word_t PAGE_PERM_MASK = 32'h0000_0FFC;
    localparam word_t SEC_ADDR_MASK  = 32'hFFF0_0000;
    localparam word_t LPG_ADDR_MASK  = 32'hFFFF_0000;
    localparam word_t SPG_ADDR_MASK  = 32'hFFFF_F000;
    localparam word_t WORD_ALIGN     = 32'hFFFF_FFFC;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_SECTION = 2'd1,
        FLT_PAGE    = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        MAP_INVALID = 2'd0,
        MAP_SMALL   = 2'd1,
        MAP_LARGE   = 2'd2,
        MAP_SECTION = 2'd3
    } map_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_DONE    = 3'd5
    } walk_st_e;

    typedef struct packed {
        word_t va;
        word_t pa;
        word_t perm;
        dom_t  dom;
        map_e  map;
    } fill_t;

    function automatic word_t first_level_addr(input word_t base, input word_t va);
        return ((base & L1_BASE_MASK) | (va >> L1_SHIFT)) & WORD_ALIGN;
    endfunction

    function automatic word_t second_level_addr(input word_t d1, input word_t va);
        return ((d1 & L2_BASE_MASK) | ((va & L2_INDEX_MASK) >> L2_SHIFT)) & WORD_ALIGN;
    endfunction

    function automatic word_t map_mask(input map_e m);
        case (m)
            MAP_SECTION: return SEC_ADDR_MASK;
            MAP_LARGE:   return LPG_ADDR_MASK;
            MAP_SMALL:   return SPG_ADDR_MASK;
            default:     return '0;
        endcase
    endfunction

    function automatic dom_t desc_domain(input word_t d1);
        return d1[DOM_LSB +: DOM_W];
    endfunction

endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
    import xw_pkg::*;
(
    input  word_t base,
    input  word_t va,
    input  word_t d1,
    input  logic  sel_l2,
    output word_t addr
);
    word_t l1_a;
    word_t l2_a;

    always_comb begin
        l1_a = first_level_addr(base, va);
        l2_a = second_level_addr(d1, va);
        addr = sel_l2 ? l2_a : l1_a;
    end
endmodule

// File: rtl/xw_desc_dec.sv
module xw_desc_dec
    import xw_pkg::*;
(
    input  word_t  va,
    input  word_t  d1,
    input  word_t  d2,
    input  logic   is_l2,
    output fault_e flt,
    output logic   go_l2,
    output fill_t  fill
);
    map_e  map;
    word_t src;
    word_t mask;

    always_comb begin
        flt   = FLT_NONE;
        go_l2 = 1'b0;
        map   = MAP_INVALID;
        src   = d1;
        fill.perm = '0;
        if (!is_l2) begin
            case (d1[1:0])
                2'd2: begin
                    map       = MAP_SECTION;
                    fill.perm = d1 & SEC_PERM_MASK;
                end
                2'd1: go_l2 = 1'b1;
                default: flt = FLT_SECTION;
            endcase
        end else begin
            src       = d2;
            fill.perm = d2 & PAGE_PERM_MASK;
            case (d2[1:0])
                2'd1: map = MAP_LARGE;
                2'd2: map = MAP_SMALL;
                default: flt = FLT_PAGE;
            endcase
        end
        mask     = map_mask(map);
        fill.va  = va & mask;
        fill.pa  = src & mask;
        fill.dom = desc_domain(d1);
        fill.map = map;
    end
endmodule

// File: rtl/xw_ctrl.sv
module xw_ctrl
    import xw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic walk_req,
    input  logic mem_valid,
    input  logic go_l2,
    output logic accept,
    output logic mem_req,
    output logic sel_l2,
    output logic l1_wait,
    output logic l2_wait,
    output logic cap_d1,
    output logic finish,
    output logic done,
    output logic busy
);
    walk_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:    if (walk_req) st_d = ST_L1_REQ;
            ST_L1_REQ:  st_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_valid) st_d = go_l2 ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  st_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_valid) st_d = ST_DONE;
            ST_DONE:    st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        accept  = (st_q == ST_IDLE) && walk_req;
        mem_req = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
        sel_l2  = (st_q == ST_L2_REQ);
        l1_wait = (st_q == ST_L1_WAIT);
        l2_wait = (st_q == ST_L2_WAIT);
        cap_d1  = l1_wait && mem_valid;
        finish  = (cap_d1 && !go_l2) || (l2_wait && mem_valid);
        done    = (st_q == ST_DONE);
        busy    = (st_q != ST_IDLE);
    end
endmodule

// File: rtl/xw_result.sv
module xw_result
    import xw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  fault_e flt,
    input  fill_t  fill,
    output fault_e flt_q,
    output fill_t  fill_q,
    output dom_t   last_dom_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flt_q      <= FLT_NONE;
            fill_q     <= '0;
            last_dom_q <= '0;
        end else if (load) begin
            flt_q <= flt;
            if (flt == FLT_NONE) fill_q <= fill;
            if (flt != FLT_SECTION) last_dom_q <= fill.dom;
        end
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        walk_req,
    input  logic [31:0] walk_va,
    input  logic [31:0] tbl_base,
    output logic        busy,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_valid,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic [1:0]  fault,
    output logic [31:0] fill_va,
    output logic [31:0] fill_pa,
    output logic [31:0] fill_perm,
    output logic [3:0]  fill_domain,
    output logic [1:0]  fill_map,
    output logic [3:0]  last_domain
);
    word_t  va_q, base_q, d1_q, d1_live;
    logic   accept, sel_l2, l1_wait, l2_wait, cap_d1, finish, go_l2;
    fault_e flt, flt_q;
    fill_t  fill, fill_q;
    dom_t   last_dom_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q   <= '0;
            base_q <= '0;
            d1_q   <= '0;
        end else begin
            if (accept) begin
                va_q   <= walk_va;
                base_q <= tbl_base;
            end
            if (cap_d1) d1_q <= mem_rdata;
        end
    end

    assign d1_live = l1_wait ? mem_rdata : d1_q;

    xw_ctrl u_ctrl (
        .clk(clk), .rst(rst), .walk_req(walk_req), .mem_valid(mem_valid),
        .go_l2(go_l2), .accept(accept), .mem_req(mem_req), .sel_l2(sel_l2),
        .l1_wait(l1_wait), .l2_wait(l2_wait), .cap_d1(cap_d1),
        .finish(finish), .done(done), .busy(busy)
    );

    xw_addr_gen u_addr (
        .base(base_q), .va(va_q), .d1(d1_q), .sel_l2(sel_l2), .addr(mem_addr)
    );

    xw_desc_dec u_dec (
        .va(va_q), .d1(d1_live), .d2(mem_rdata), .is_l2(l2_wait),
        .flt(flt), .go_l2(go_l2), .fill(fill)
    );

    xw_result u_res (
        .clk(clk), .rst(rst), .load(finish), .flt(flt), .fill(fill),
        .flt_q(flt_q), .fill_q(fill_q), .last_dom_q(last_dom_q)
    );

    assign fault       = flt_q;
    assign fill_va     = fill_q.va;
    assign fill_pa     = fill_q.pa;
    assign fill_perm   = fill_q.perm;
    assign fill_domain = fill_q.dom;
    assign fill_map    = fill_q.map;
    assign last_domain = last_dom_q;
endmodule

// File: rtl/xw_chk.sv
module xw_chk (
    input logic       clk,
    input logic       rst,
    input logic       walk_req,
    input logic       busy,
    input logic       mem_req,
    input logic [1:0] mem_addr_lo,
    input logic       done,
    input logic [1:0] fault,
    input logic [3:0] last_domain
);
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);                                        // R2
    AST_REQ_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr_lo == 2'b00);                            // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));                                   // R9
    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> fault != 2'b11);                                     // R9
    AST_SECT_FAULT_KEEPS_DOMAIN: assert property (@(posedge clk) disable iff (rst)
        (done && fault == 2'd1) |-> last_domain == $past(last_domain)); // R3
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);                                          // R11
    AST_IDLE_REQ_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!busy && walk_req) |=> mem_req);                             // R2
endmodule

bind xlat_walker xw_chk u_chk (
    .clk(clk), .rst(rst), .walk_req(walk_req), .busy(busy), .mem_req(mem_req),
    .mem_addr_lo(mem_addr[1:0]), .done(done), .fault(fault),
    .last_domain(last_domain)
);

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        walk_req = 1'b0;
    logic [31:0] walk_va = '0, tbl_base = '0;
    logic        busy, mem_req, done;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  fault, fill_map;
    logic [31:0] fill_va, fill_pa, fill_perm;
    logic [3:0]  fill_domain, last_domain;

    always #10 clk = ~clk;

    xlat_walker u0 (
        .clk(clk), .rst(rst), .walk_req(walk_req), .walk_va(walk_va),
        .tbl_base(tbl_base), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .fill_va(fill_va), .fill_pa(fill_pa), .fill_perm(fill_perm),
        .fill_domain(fill_domain), .fill_map(fill_map), .last_domain(last_domain)
    );

    typedef struct {
        logic [1:0]  flt;
        logic [31:0] va, pa, perm;
        logic [3:0]  dom;
        logic [1:0]  map;
        logic [3:0]  ldom;
        string       tag;
    } exp_t;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_addr_q[$];
    exp_t        exp_q[$];
    int          nvec = 0, nfail = 0, ndone = 0, lat = 1;
    logic [3:0]  ldom_m = 4'd0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory model: checks each read address, answers after lat cycles
    int          cnt = 0;
    logic [31:0] pend_a = '0;
    always @(negedge clk) begin
        mem_valid = 1'b0;
        if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                mem_valid = 1'b1;
                mem_rdata = rd(pend_a);
            end
        end
        if (!rst && mem_req) begin
            if (exp_addr_q.size() == 0) chk("R3/R11 unexpected read", mem_addr, 32'hxxxx_xxxx);
            else chk("R2/R5 read address", mem_addr, exp_addr_q.pop_front());
            pend_a = mem_addr;
            cnt = lat;
        end
    end

    // monitor: compares each completion with the scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            ndone++;
            if (exp_q.size() == 0) chk("R9/R11 extra done", 32'd1, 32'd0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " fault"}, {30'd0, fault}, {30'd0, e.flt});
                if (e.flt == 2'd0) begin
                    chk({e.tag, " fill_va"}, fill_va, e.va);
                    chk({e.tag, " fill_pa"}, fill_pa, e.pa);
                    chk({e.tag, " fill_perm"}, fill_perm, e.perm);
                    chk({e.tag, " fill_domain"}, {28'd0, fill_domain}, {28'd0, e.dom});
                    chk({e.tag, " fill_map"}, {30'd0, fill_map}, {30'd0, e.map});
                end
                chk({e.tag, " last_domain"}, {28'd0, last_domain}, {28'd0, e.ldom});
            end
        end
    end

    // reference model from the requirements, fills the scoreboard
    task automatic expect_walk(input logic [31:0] va, input logic [31:0] base, input string tag);
        exp_t e;
        logic [31:0] a1, a2, d1, d2, m;
        e.tag = tag; e.flt = 2'd0; e.va = '0; e.pa = '0; e.perm = '0; e.dom = '0; e.map = '0;
        a1 = ((base & 32'hFFFFC000) | (va >> 18)) & 32'hFFFFFFFC;
        exp_addr_q.push_back(a1);
        d1 = rd(a1);
        if (d1[1:0] == 2'd2) begin                       // R4 section
            e.map = 2'd3; m = 32'hFFF00000;
            e.va = va & m; e.pa = d1 & m; e.perm = d1 & 32'h00000C0C;
            e.dom = d1[8:5]; ldom_m = d1[8:5];           // R10
        end else if (d1[1:0] == 2'd1) begin
            a2 = ((d1 & 32'hFFFFFC00) | ((va & 32'h000FF000) >> 10)) & 32'hFFFFFFFC;
            exp_addr_q.push_back(a2);
            d2 = rd(a2);
            e.dom = d1[8:5];
            if (d2[1:0] == 2'd1 || d2[1:0] == 2'd2) begin // R7 R8
                e.map = (d2[1:0] == 2'd1) ? 2'd2 : 2'd1;
                m = (d2[1:0] == 2'd1) ? 32'hFFFF0000 : 32'hFFFFF000;
                e.va = va & m; e.pa = d2 & m; e.perm = d2 & 32'h00000FFC;
            end else e.flt = 2'd2;                        // R6
            ldom_m = d1[8:5];
        end else e.flt = 2'd1;                            // R3: domain kept
        e.ldom = ldom_m;
        exp_q.push_back(e);
    endtask

    task automatic run_walk(input logic [31:0] va, input logic [31:0] base, input int l,
                            input bit poke, input string tag);
        int target;
        lat = l;
        expect_walk(va, base, tag);
        target = ndone + 1;
        @(negedge clk);
        walk_req = 1'b1; walk_va = va; tbl_base = base;
        @(negedge clk);
        walk_req = 1'b0;
        if (poke) begin                                  // R11 request while busy
            @(negedge clk);
            walk_req = 1'b1; walk_va = ~va; tbl_base = ~base;
            @(negedge clk);
            walk_req = 1'b0;
        end
        while (ndone < target) @(negedge clk);
        @(negedge clk);
        chk({tag, " R9 done low after pulse"}, {31'd0, done}, 32'd0);
        chk({tag, " R9 busy low after done"}, {31'd0, busy}, 32'd0);
        chk({tag, " R3/R11 no reads left"}, exp_addr_q.size(), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [31:0] base;
        base = 32'h0001_2345;  // L1 table at 0x00010000
        // section at va 0x00300000 (index 0xC), domain 5
        mem[32'h0001_000C] = 32'hABC5_5CAE;
        // section fault type 0 at va 0x00400000, type 3 at va 0x00500000
        mem[32'h0001_0010] = 32'h0000_01E0;
        mem[32'h0001_0014] = 32'h1234_0163;
        // coarse table at 0x00020400, domain 9 (va 0x00600000)
        mem[32'h0001_0018] = 32'h0002_0531;
        // va 0x00634xxx -> index 0x34 -> addr 0x000204D0 : large page
        mem[32'h0002_04D0] = 32'h7654_3A5D;
        // va 0x00677xxx -> index 0x77 -> addr 0x000205DC : small page
        mem[32'h0002_05DC] = 32'h89AB_CDEE;
        // va 0x00611xxx -> index 0x11 -> addr 0x00020444 : fault type 0
        mem[32'h0002_0444] = 32'h0000_0000;
        // va 0x00622xxx -> index 0x22 -> addr 0x00020488 : fault type 3
        mem[32'h0002_0488] = 32'hFFFF_FFFF;
        // second table, domain 2 (va 0x00700000)
        mem[32'h0001_001C] = 32'h0003_0841;
        mem[32'h0003_0804] = 32'h0BAD_F00E;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy at reset", {31'd0, busy}, 32'd0);
        chk("R1 done at reset", {31'd0, done}, 32'd0);
        chk("R1 mem_req at reset", {31'd0, mem_req}, 32'd0);
        chk("R1 last_domain at reset", {28'd0, last_domain}, 32'd0);

        run_walk(32'h0030_1234, base, 1, 0, "R4 section");
        run_walk(32'h0040_0008, base, 2, 0, "R3 section fault type0");
        run_walk(32'h0050_0000, base, 1, 0, "R3 section fault type3");
        run_walk(32'h0063_4ABC, base, 3, 0, "R7 large page");
        run_walk(32'h0067_7FFF, base, 1, 0, "R8 small page");
        run_walk(32'h0061_1000, base, 2, 0, "R6 page fault type0");
        run_walk(32'h0050_0000, base, 1, 0, "R3 fault after page fault");
        run_walk(32'h0062_2010, base, 1, 0, "R6 page fault type3");
        run_walk(32'h0070_1004, base, 7, 0, "R12 long latency small page");
        run_walk(32'h0030_0000, base, 4, 1, "R11 ignored request");
        run_walk(32'h0063_4000, base, 5, 1, "R10 R11 ignored during page walk");

        repeat (5) @(negedge clk);
        chk("R11 no extra done", ndone, 32'd11);
        chk("R11 idle after walks", {31'd0, busy}, 32'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule